// File: doc/BRIEF.md
# Incremental ADC Conversion Sequencer

This block is the digital half of a first-order, reset-type oversampling converter. An external analog loop (an integrator, a comparator and two references) hands the block one decision bit per clock. The block returns a reference-select line that tells the loop which reference to subtract next, and an integrator-clear line. Each conversion runs a fixed integrate window. During the window the block counts the cycles on which the decision bit is high. A short clear phase follows, in which that count is frozen into the output register and the integrator is emptied for the next sample.

The count over a window of W cycles encodes the input as a density. If the references sit at plus and minus full scale about mid-supply ground, a count of W/2 means zero input, and W (or W-1) means positive full scale. The window is chosen from four lengths by a 2-bit select. A longer window gains resolution at the cost of output rate: each doubling of the window adds one bit and halves the sample rate.

Top module: `inc_adc_seq`

## Requirements
- R1: While `rst_n` is low, `integ_zero` is 1, `ref_sel` is 0, `sample_valid` is 0 and `sample_out` is 0, whatever `cmp_bit` does.
- R2: The clear phase (`integ_zero` = 1) lasts exactly 2 cycles. It begins right after reset is released and again after every integrate window.
- R3: The integrate phase (`integ_zero` = 0) lasts W cycles. W is 256 for `win_sel` = 0, 1024 for 1, 4096 for 2 and 65536 for 3.
- R4: During the integrate phase `ref_sel` equals `cmp_bit` in the same cycle, where 1 selects the positive reference. During the clear phase `ref_sel` is 0.
- R5: The result is the number of integrate cycles in which `cmp_bit` was 1. The result is captured at the end of the first clear cycle and appears on `sample_out` from the second clear cycle. It then holds until the next capture.
- R6: A count equal to W, meaning every cycle was 1, is reported as W-1, so every result fits in log2(W) bits.
- R7: `sample_valid` is a one-cycle pulse in the second clear cycle of each conversion. The capture in the first clear phase after reset produces no pulse.
- R8: `win_sel` is sampled only in the last clear cycle. A change during an integrate window leaves that window's length unchanged.
- R9: Run in a first-order loop with a constant input x within ±FS, the result n satisfies |2·FS·n − W·(x+FS)| ≤ 2·FS. That is, n is within one count of the ideal density.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmp_bit | input | 1 | Comparator decision from the analog loop |
| win_sel | input | 2 | Integrate window length select |
| ref_sel | output | 1 | Reference select fed to the loop (1 = positive) |
| integ_zero | output | 1 | Integrator clear, active high |
| sample_out | output | 16 | Latched ones-count of the last window |
| sample_valid | output | 1 | One-cycle strobe for a new result |

## Verification
A phase counter that is off by even one cycle moves the falling edge of `integ_zero` in the first window. A per-cycle comparison with a behavioural sequence model catches this within a few hundred cycles. A window register that loads at the wrong time, or a missing saturation, shows up at the next `sample_valid` as a wrong window length or an out-of-range count. A fault in the ones counter or in its clear surfaces as a wrong `sample_out` at the end of the first window it touches. The loop model then also shows it as a density that breaks the one-count bound.

// File: rtl/inc_adc_pkg.sv
package inc_adc_pkg;

  typedef enum logic {
    PH_CLEAR = 1'b0,
    PH_INTEG = 1'b1
  } phase_e;

  function automatic int unsigned pick_log(input int unsigned idx,
                                           input int unsigned l0,
                                           input int unsigned l1,
                                           input int unsigned l2,
                                           input int unsigned l3);
    case (idx)
      0: return l0;
      1: return l1;
      2: return l2;
      default: return l3;
    endcase
  endfunction

  function automatic int unsigned max_log(input int unsigned l0,
                                          input int unsigned l1,
                                          input int unsigned l2,
                                          input int unsigned l3);
    int unsigned m;
    m = l0;
    if (l1 > m) m = l1;
    if (l2 > m) m = l2;
    if (l3 > m) m = l3;
    return m;
  endfunction

endpackage

// File: rtl/inc_adc_phase_ctrl.sv
module inc_adc_phase_ctrl
  import inc_adc_pkg::*;
#(
  parameter int unsigned LOG_W0 = 8,
  parameter int unsigned LOG_W1 = 10,
  parameter int unsigned LOG_W2 = 12,
  parameter int unsigned LOG_W3 = 16,
  parameter int unsigned CNT_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       win_sel,
  output logic             clear_o,
  output logic             capture_o,
  output logic [CNT_W-1:0] win_len_o
);

  localparam int unsigned CLEAR_CYC = 2;
  localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(CLEAR_CYC - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] len_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    localparam int unsigned LG = pick_log(g, LOG_W0, LOG_W1, LOG_W2, LOG_W3);
    assign len_tab[g] = ONE << LG;
  end

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    phase_d = phase_q;
    pcnt_d  = pcnt_q + ONE;
    win_en  = 1'b0;
    win_d   = len_tab[win_sel];
    case (phase_q)
      PH_CLEAR: begin
        if (pcnt_q == CLEAR_LAST) begin
          phase_d = PH_INTEG;
          pcnt_d  = '0;
          win_en  = 1'b1;
        end
      end
      default: begin
        if (pcnt_q == win_q - ONE) begin
          phase_d = PH_CLEAR;
          pcnt_d  = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CLEAR;
      pcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= ONE << LOG_W0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign clear_o   = (phase_q == PH_CLEAR);
  assign capture_o = clear_o && (pcnt_q == '0);
  assign win_len_o = win_q;

  // R2: clear phase is exactly two cycles long
  p_clear_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_o) |=> clear_o ##1 !clear_o)
    else $error("clear phase length wrong");

  // R3: position inside the window never reaches the window length
  p_win_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_o |-> (pcnt_q < win_q))
    else $error("window position out of range");

  // R8: window length frozen across an integrate phase
  p_win_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_o && !$past(clear_o)) |-> $stable(win_q))
    else $error("window length changed mid window");

endmodule

// File: rtl/inc_adc_ones_count.sv
module inc_adc_ones_count #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             bit_i,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] win_len_i,
  output logic [CNT_W-2:0] sample_o,
  output logic             valid_o
);

  localparam int unsigned RES = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ones_q, ones_d;
  logic [RES-1:0]   sample_q;
  logic [CNT_W-1:0] sat_w;
  logic             valid_q, valid_d;
  logic             armed_q;
  logic             ones_en;

  // full-density count of W is clipped to W-1
  assign sat_w = (ones_q >= win_len_i) ? (win_len_i - ONE) : ones_q;

  always_comb begin
    ones_en = capture_i || (count_en && bit_i);
    ones_d  = capture_i ? '0 : (ones_q + ONE);
    valid_d = capture_i && armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (ones_en) begin
      ones_q <= ones_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else if (capture_i) begin
      sample_q <= sat_w[RES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (capture_i) armed_q <= 1'b1;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  // R6: the raw count never exceeds the window length
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= win_len_i)
    else $error("ones count above window length");

  // R6: every presented result fits below the window length
  p_sample_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ({1'b0, sample_q} < win_len_i))
    else $error("result not clipped");

  // R7: strobe lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q)
    else $error("valid longer than one cycle");

  // R5: result changes only together with its strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q != $past(sample_q)) |-> valid_q)
    else $error("result changed without strobe");

endmodule

// File: rtl/inc_adc_seq.sv
module inc_adc_seq
  import inc_adc_pkg::*;
#(
  parameter int unsigned LOG_W0 = 8,
  parameter int unsigned LOG_W1 = 10,
  parameter int unsigned LOG_W2 = 12,
  parameter int unsigned LOG_W3 = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_bit,
  input  logic [1:0]  win_sel,
  output logic        ref_sel,
  output logic        integ_zero,
  output logic [max_log(LOG_W0, LOG_W1, LOG_W2, LOG_W3)-1:0] sample_out,
  output logic        sample_valid
);

  localparam int unsigned RES_MAX = max_log(LOG_W0, LOG_W1, LOG_W2, LOG_W3);
  localparam int unsigned CNT_W   = RES_MAX + 1;

  logic             clear_w;
  logic             capture_w;
  logic [CNT_W-1:0] win_len_w;

  inc_adc_phase_ctrl #(
    .LOG_W0(LOG_W0), .LOG_W1(LOG_W1), .LOG_W2(LOG_W2), .LOG_W3(LOG_W3),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_sel   (win_sel),
    .clear_o   (clear_w),
    .capture_o (capture_w),
    .win_len_o (win_len_w)
  );

  inc_adc_ones_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (!clear_w),
    .bit_i     (cmp_bit),
    .capture_i (capture_w),
    .win_len_i (win_len_w),
    .sample_o  (sample_out),
    .valid_o   (sample_valid)
  );

  assign integ_zero = clear_w;
  assign ref_sel    = !clear_w && cmp_bit;

  // R4: no reference is selected while the integrator is held clear
  p_ref_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    integ_zero |-> !ref_sel)
    else $error("reference selected during clear");

  // R7: strobe only in the second clear cycle
  p_valid_in_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (integ_zero && $past(integ_zero)))
    else $error("strobe outside clear phase");

endmodule

// File: tb/inc_adc_seq_test.sv
`timescale 1ns/1ps
module inc_adc_seq_test;

  localparam int FS = 1000;
  localparam int MAX_CYC = 190000;

  logic        clk;
  logic        rst_n;
  logic        cmp_bit;
  logic [1:0]  win_sel;
  logic        ref_sel;
  logic        integ_zero;
  logic [15:0] sample_out;
  logic        sample_valid;

  inc_adc_seq uut (
    .clk(clk), .rst_n(rst_n), .cmp_bit(cmp_bit), .win_sel(win_sel),
    .ref_sel(ref_sel), .integ_zero(integ_zero),
    .sample_out(sample_out), .sample_valid(sample_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // stimulus state
  int cur_x = 0;
  logic [1:0] cur_sel = 2'd0;
  longint acc = 0;

  // behavioural reference state
  bit  m_zero = 1;
  int  m_pc = 0;
  int  m_W = 256;
  int  m_ones = 0;
  int  m_sample = 0;
  bit  m_valid = 0;
  bit  m_first = 1;
  int  m_xw = 0;
  bit  got_valid = 0;

  function automatic int win_of(input logic [1:0] s);
    case (s)
      2'd0: return 256;
      2'd1: return 1024;
      2'd2: return 4096;
      default: return 65536;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit drive_rst_n);
    logic c;
    @(negedge clk);
    got_valid = 0;
    // outputs reflect state after the last edge
    chk(integ_zero === m_zero, "R2/R3 integ_zero", longint'(integ_zero), longint'(m_zero));
    chk(sample_valid === m_valid, "R7 sample_valid", longint'(sample_valid), longint'(m_valid));
    chk(sample_out === 16'(m_sample), "R5 sample_out", longint'(sample_out), longint'(m_sample));
    if (m_valid) begin
      got_valid = 1;
      // R9: loop density within one count of ideal
      chk((2*longint'(FS)*longint'(sample_out) - longint'(m_W)*longint'(m_xw + FS) <= 2*longint'(FS)) &&
          (2*longint'(FS)*longint'(sample_out) - longint'(m_W)*longint'(m_xw + FS) >= -2*longint'(FS)),
          "R9 density", longint'(sample_out), longint'(m_W)*longint'(m_xw + FS)/(2*FS));
      // R6: result below window length
      chk(int'(sample_out) < m_W, "R6 clipped", longint'(sample_out), longint'(m_W - 1));
    end
    // drive inputs
    c = m_zero ? 1'b1 : (acc >= 0);
    cmp_bit = c;
    win_sel = cur_sel;
    rst_n   = drive_rst_n;
    #1;
    if (!drive_rst_n) begin
      // R1: outputs in reset
      chk(integ_zero === 1'b1 && ref_sel === 1'b0 && sample_valid === 1'b0 && sample_out === 16'd0,
          "R1 reset outputs", longint'({integ_zero, ref_sel, sample_valid}), 64'd4);
    end
    chk(ref_sel === (m_zero ? 1'b0 : c), "R4 ref_sel", longint'(ref_sel), longint'(m_zero ? 1'b0 : c));
    // loop model
    if (m_zero) acc = 0;
    else acc = acc + cur_x - (c ? FS : -FS);
    // sequence model next state
    if (!drive_rst_n) begin
      m_zero = 1; m_pc = 0; m_W = 256; m_ones = 0;
      m_sample = 0; m_valid = 0; m_first = 1;
    end else if (m_zero) begin
      if (m_pc == 0) begin
        m_sample = (m_ones >= m_W) ? m_W - 1 : m_ones;
        m_valid  = !m_first;
        m_first  = 0;
        m_ones   = 0;
        m_pc     = 1;
      end else begin
        m_valid = 0;
        m_W     = win_of(cur_sel);  // R8: only sampled here
        m_zero  = 0;
        m_pc    = 0;
      end
    end else begin
      m_valid = 0;
      if (m_pc == 0) m_xw = cur_x;
      if (c) m_ones++;
      if (m_pc == m_W - 1) begin
        m_zero = 1;
        m_pc   = 0;
      end else begin
        m_pc++;
      end
    end
  endtask

  task automatic run(input logic [1:0] sel, input int x, input int n);
    cur_sel = sel;
    cur_x   = x;
    for (int i = 0; i < n; i++) begin
      do step(1'b1); while (!got_valid);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    cmp_bit = 1'b1;
    win_sel = 2'd0;
    for (int i = 0; i < 4; i++) step(1'b0);   // R1
    step(1'b1);                                // release
    // R7: first capture after reset gives no strobe (compared every cycle)
    run(2'd0, 0, 2);        // mid scale
    run(2'd0, 300, 1);
    run(2'd0, -700, 1);
    run(2'd0, FS, 1);       // R6 all ones, saturate
    run(2'd0, FS, 1);
    run(2'd0, -FS, 1);
    run(2'd0, -FS, 1);
    // R8: toggle select mid window, length must not change
    cur_x = 1;
    for (int i = 0; i < 30; i++) step(1'b1);
    cur_sel = 2'd3;
    for (int i = 0; i < 100; i++) step(1'b1);
    cur_sel = 2'd0;
    run(2'd0, 1, 2);
    // R3: other window lengths (select takes effect one window later)
    run(2'd1, 300, 1);
    run(2'd2, -250, 1);
    run(2'd3, 123, 1);
    run(2'd0, 777, 2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(MAX_CYC * 5.0);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule